// File: doc/BRIEF.md
# Interval Timer Channel

One counting channel of a classic programmable interval timer. The channel advances on a timer-tick enable, holds a programmed mode and an initial count, and drives a single output whose waveform is set by the mode: a terminal-count level, a periodic one-tick pulse, a square wave, or a single one-tick strobe. A gate input either pauses counting or, in the retriggerable modes, restarts it.

Host logic loads a new mode and count in one clock with `load_en`. From that clock the channel measures elapsed ticks and derives `out_o` from them. `next_edge_o` warns one tick ahead that `out_o` is about to change, so an interrupt controller can be armed early. Status outputs report the sampled gate, the programmed mode and the effective count.

Top module: `pit_channel`

## Requirements
- R1: A clock with `load_en` high stores `load_mode` and `load_count` and restarts elapsed ticks at zero. A `load_count` of 0 is stored as 65536. A load beats a tick or a gate edge in the same clock.
- R2: `load_mode` is a 3-bit binary mode number. Modes 0, 1, 6 and 7 hold `out_o` low while the elapsed ticks are below the count. From the tick where they reach the count, `out_o` is high and stays high.
- R3: In mode 2, `out_o` is high for one tick each time the elapsed ticks equal a nonzero multiple of the count, and low otherwise.
- R4: In mode 3, `out_o` is high while (elapsed mod count) is below (count+1)/2 and low otherwise. An odd count therefore gives the longer half to the high phase.
- R5: In modes 4 and 5, `out_o` is high only on the one tick where the elapsed ticks equal the count. It is low before and after.
- R6: In modes 0, 2, 3, 4, 6 and 7, ticks that arrive while `gate_in` is low do not advance the elapsed count.
- R7: In modes 1 and 5, the gate level does not stop counting. A clock where `gate_in` is high after being low at the previous clock restarts the elapsed ticks at zero, and this restart beats a tick in the same clock.
- R8: `next_edge_o` is high exactly when the next tick that advances the count will change `out_o`.
- R9: Reset puts the channel in mode 3 with count 65536, elapsed ticks at zero, and the gate status at parameter `GATE_RST`. `out_o` is therefore high.
- R10: `stat_gate` shows `gate_in` as sampled at the previous clock. `stat_mode` shows the mode as programmed. `stat_count` shows the effective count (17 bits, so 65536 can be shown).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; one tick per clock where high |
| load_en | input | 1 | Load mode and count this clock |
| load_mode | input | 3 | Mode number to load |
| load_count | input | CNT_W | Initial count to load (0 means 2^CNT_W) |
| gate_in | input | 1 | Gate input |
| out_o | output | 1 | Channel output waveform |
| next_edge_o | output | 1 | Next advancing tick changes `out_o` |
| stat_gate | output | 1 | Sampled gate level |
| stat_mode | output | 3 | Programmed mode |
| stat_count | output | CNT_W+1 | Effective count |

## Verification
Two pairs of events can land in the same clock: a restart (from a load, or from a gate rising edge in a retriggerable mode) and a tick. The bench lines up a gate rising edge with an active tick in mode 1 after three ticks have elapsed. It then checks that `out_o` reaches the terminal level only after four further ticks, which shows the colliding tick was dropped. A load with a tick in the same clock is checked the same way: the count to the output rise is measured from the load clock.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [1:0] {
    CLS_TERM   = 2'd0,
    CLS_RATE   = 2'd1,
    CLS_SQUARE = 2'd2,
    CLS_STROBE = 2'd3
  } out_cls_e;

  function automatic out_cls_e cls_of(input logic [2:0] m);
    case (m)
      3'd2:       return CLS_RATE;
      3'd3:       return CLS_SQUARE;
      3'd4, 3'd5: return CLS_STROBE;
      default:    return CLS_TERM;
    endcase
  endfunction

  function automatic logic is_retrig(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd5);
  endfunction

  function automatic logic is_periodic(input out_cls_e c);
    return (c == CLS_RATE) || (c == CLS_SQUARE);
  endfunction

endpackage

// File: rtl/pit_out_fn.sv
module pit_out_fn
  import pit_chan_pkg::*;
#(
  parameter int EW = 17
) (
  input  out_cls_e         cls,
  input  logic [EW-1:0]    phase,
  input  logic [EW-1:0]    count,
  input  logic             run,
  output logic             out
);

  logic [EW:0] half;

  always_comb begin
    half = ({1'b0, count} + 1'b1) >> 1;
    case (cls)
      CLS_RATE:   out = run && (phase == '0);
      CLS_SQUARE: out = ({1'b0, phase} < half);
      CLS_STROBE: out = (phase == count);
      default:    out = (phase >= count);
    endcase
  end

endmodule

// File: rtl/pit_phase_ctr.sv
module pit_phase_ctr #(
  parameter int EW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          periodic,
  input  logic [EW-1:0] count,
  output logic [EW-1:0] ph_q,
  output logic          run_q,
  output logic [EW-1:0] ph_adv
);

  logic [EW-1:0] ph_d;
  logic          run_d;

  always_comb begin
    if (periodic) begin
      ph_adv = (ph_q == count - 1'b1) ? '0 : ph_q + 1'b1;
    end else begin
      ph_adv = (ph_q > count) ? ph_q : ph_q + 1'b1;
    end
  end

  always_comb begin
    ph_d  = ph_q;
    run_d = run_q;
    if (clear) begin
      ph_d  = '0;
      run_d = 1'b0;
    end else if (step) begin
      ph_d  = ph_adv;
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      run_q <= run_d;
    end
  end

  // R6: without a step or a clear the elapsed phase must not move
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(ph_q))
    else $error("phase moved without a step");

  // R1 / R7: a restart always lands on phase zero, not yet running
  a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ph_q == '0 && !run_q))
    else $error("restart did not clear phase");

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int   CNT_W    = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_count,
  input  logic             gate_in,
  output logic             out_o,
  output logic             next_edge_o,
  output logic             stat_gate,
  output logic [2:0]       stat_mode,
  output logic [CNT_W:0]   stat_count
);

  localparam int            EW   = CNT_W + 1;
  localparam logic [EW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [2:0]    MODE_RST = 3'd3;

  logic [2:0]    mode_q, mode_d;
  logic [EW-1:0] count_q, count_d;
  logic          gate_q;

  out_cls_e      cls;
  logic          retrig, gate_rise, restart, may_run, step;
  logic [EW-1:0] ph_q, ph_adv;
  logic          run_q, out_adv;

  always_comb begin
    cls       = cls_of(mode_q);
    retrig    = is_retrig(mode_q);
    gate_rise = gate_in && !gate_q;
    restart   = load_en || (retrig && gate_rise);
    may_run   = retrig || gate_in;
    step      = tick_en && may_run && !restart;
  end

  always_comb begin
    mode_d  = mode_q;
    count_d = count_q;
    if (load_en) begin
      mode_d  = load_mode;
      count_d = (load_count == '0) ? FULL : {1'b0, load_count};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      count_q <= FULL;
      gate_q  <= GATE_RST;
    end else begin
      mode_q  <= mode_d;
      count_q <= count_d;
      gate_q  <= gate_in;
    end
  end

  pit_phase_ctr #(.EW(EW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .step     (step),
    .periodic (is_periodic(cls)),
    .count    (count_q),
    .ph_q     (ph_q),
    .run_q    (run_q),
    .ph_adv   (ph_adv)
  );

  pit_out_fn #(.EW(EW)) u_out_now (
    .cls   (cls),
    .phase (ph_q),
    .count (count_q),
    .run   (run_q),
    .out   (out_o)
  );

  pit_out_fn #(.EW(EW)) u_out_next (
    .cls   (cls),
    .phase (ph_adv),
    .count (count_q),
    .run   (1'b1),
    .out   (out_adv)
  );

  assign next_edge_o = may_run && (out_adv != out_o);
  assign stat_gate   = gate_q;
  assign stat_mode   = mode_q;
  assign stat_count  = count_q;

  // R1: the stored count is never zero
  a_r1_count_nz: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q != '0))
    else $error("zero count stored");

  // R2: terminal level holds until a restart
  a_r2_term_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_TERM && out_o && !restart) |=> out_o)
    else $error("terminal level dropped");

  // R5: a strobe lasts one advancing tick
  a_r5_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_STROBE && out_o && step) |=> !out_o)
    else $error("strobe longer than one tick");

  // R8: a warned tick changes the output
  a_r8_edge_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (next_edge_o && tick_en && !restart) |=> (out_o != $past(out_o)))
    else $error("warned edge did not occur");

  // R8: without a warning or restart the output holds
  a_r8_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!next_edge_o && !restart) |=> $stable(out_o))
    else $error("unwarned output change");

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, load_en, gate_in;
  logic [2:0]  load_mode;
  logic [15:0] load_count;
  logic        out_o, next_edge_o, stat_gate;
  logic [2:0]  stat_mode;
  logic [16:0] stat_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_mode(load_mode), .load_count(load_count), .gate_in(gate_in),
    .out_o(out_o), .next_edge_o(next_edge_o), .stat_gate(stat_gate),
    .stat_mode(stat_mode), .stat_count(stat_count)
  );

  // mode, count, ticks after load (gate held high)
  localparam int VEC [0:15][0:2] = '{
    '{0, 5, 4}, '{0, 5, 5}, '{1, 3, 10}, '{2, 4, 4},
    '{2, 4, 5}, '{2, 4, 8}, '{3, 5, 2},  '{3, 5, 3},
    '{3, 5, 7}, '{3, 4, 2}, '{4, 6, 6},  '{4, 6, 7},
    '{5, 2, 2}, '{6, 3, 3}, '{7, 3, 2},  '{2, 1, 3}
  };

  function automatic int mdl_out(int m, int c, int d);
    case (m)
      2:       return ((d % c) == 0 && d != 0) ? 1 : 0;
      3:       return ((d % c) < ((c + 1) / 2)) ? 1 : 0;
      4, 5:    return (d == c) ? 1 : 0;
      default: return (d >= c) ? 1 : 0;
    endcase
  endfunction

  function automatic string req_of(int m);
    case (m)
      2:       return "R3";
      3:       return "R4";
      4, 5:    return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(int m, int c);
    load_en = 1'b1; load_mode = 3'(m); load_count = 16'(c);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_ticks(int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; load_en = 1'b0; gate_in = 1'b0;
    load_mode = '0; load_count = '0;
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9", "reset gate", int'(stat_gate), 1);
    chk("R9", "reset mode", int'(stat_mode), 3);
    chk("R9", "reset count", int'(stat_count), 65536);
    chk("R9", "reset out", int'(out_o), 1);
    rst_n = 1'b1; gate_in = 1'b1;
    @(negedge clk);

    // table walk (R2..R5, R8, R10)
    for (int i = 0; i < 16; i++) begin
      int m = VEC[i][0];
      int c = VEC[i][1];
      int n = VEC[i][2];
      do_load(m, c);
      run_ticks(n);
      chk(req_of(m), $sformatf("vec%0d out", i), int'(out_o), mdl_out(m, c, n));
      chk("R8", $sformatf("vec%0d next_edge", i), int'(next_edge_o),
          (mdl_out(m, c, n + 1) != mdl_out(m, c, n)) ? 1 : 0);
      chk("R10", $sformatf("vec%0d mode", i), int'(stat_mode), m);
      chk("R10", $sformatf("vec%0d count", i), int'(stat_count), c);
    end

    // R6 gate low suspends mode 0
    do_load(0, 4);
    run_ticks(2);
    gate_in = 1'b0;
    run_ticks(5);
    chk("R6", "suspended out", int'(out_o), 0);
    chk("R8", "suspended next_edge", int'(next_edge_o), 0);
    chk("R10", "gate status low", int'(stat_gate), 0);
    gate_in = 1'b1;
    run_ticks(1);
    chk("R8", "resumed next_edge", int'(next_edge_o), 1);
    chk("R6", "resumed out before", int'(out_o), 0);
    run_ticks(1);
    chk("R6", "resumed out at count", int'(out_o), 1);

    // R7 mode 1 counts with gate low; gate rise collides with tick
    gate_in = 1'b0;
    @(negedge clk);
    do_load(1, 4);
    run_ticks(3);
    chk("R7", "gate low no pause", int'(next_edge_o), 1);
    gate_in = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk("R7", "restart beats tick", int'(out_o), 0);
    run_ticks(3);
    chk("R7", "after restart 3", int'(out_o), 0);
    run_ticks(1);
    chk("R7", "after restart 4", int'(out_o), 1);

    // R1 load collides with tick
    do_load(0, 2);
    run_ticks(1);
    load_en = 1'b1; load_mode = 3'd0; load_count = 16'd3; tick_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0; tick_en = 1'b0;
    run_ticks(2);
    chk("R1", "load beats tick", int'(out_o), 0);
    run_ticks(1);
    chk("R1", "load then count", int'(out_o), 1);

    // R1 zero count means 65536
    do_load(0, 0);
    chk("R1", "zero count status", int'(stat_count), 65536);
    run_ticks(65535);
    chk("R1", "zero count early", int'(out_o), 0);
    chk("R8", "zero count warn", int'(next_edge_o), 1);
    run_ticks(1);
    chk("R1", "zero count end", int'(out_o), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule